// File: doc/BRIEF.md
# Handshaked Parallel Port Controller

This block runs two 8-bit general purpose ports (A and B) and a 6-bit port C for a small bus-attached peripheral chip. The bus interface in front of it decodes register accesses into per-port write pulses and read levels. The command register supplies each port's direction, the port C mode and two interrupt enables. The block drives pin output values and per-pin output enables. It returns readback data for each port and, per handshake port, an interrupt request, a buffer-full flag and the enable that gates the interrupt.

Port C is plain I/O or carries handshake lines, depending on its mode. In a handshake mode, A or B becomes a strobed port. An external strobe on a port C input latches incoming data, or acknowledges data the port has put out. The buffer-full and interrupt flags follow that exchange, so a processor can poll them or take an interrupt.

All pin inputs pass through a synchronizer before use. Every output is registered.

Top module: `pport_ctrl`

## Requirements
- R1: A synchronous active-high reset sets every output latch to zero, drives all output enables low (every port is an input) and forces every INTR and BF flag low.
- R2: An A/B port with its direction bit at 1 enables all of its pins and drives its output latch onto them. With the bit at 0 it enables none.
- R3: While a port's direction bit is 0, its output latch is held at zero and writes to it are ignored. Switching it to output therefore drives all pins low until the next write.
- R4: Reading an A/B port returns its output latch in output mode and the synchronized pin values in basic input mode.
- R5: Port C mode code 00 makes all six bits inputs and code 11 makes all six bits outputs driven from the port C latch. A read returns the driven value for enabled bits and the pin value for the others.
- R6: Mode code 01 makes port A strobed: PC0 is A INTR, PC1 is A BF, PC2 is the A strobe input, and PC3 to PC5 are plain outputs. Mode code 10 also makes port B strobed, with PC3 as B INTR, PC4 as B BF and PC5 as the B strobe input.
- R7: When a port enters a handshake mode, or changes direction while in one, BF becomes 0 and INTR becomes 1 for an output port (if enabled) and 0 for an input port. Outside a handshake mode, BF and INTR are 0.
- R8: In strobed input mode, pin data is captured while the strobe is low and reads return the captured value. The falling strobe sets BF, and the rising strobe sets INTR.
- R9: In strobed input mode, the start of a port read clears INTR and the end of the read clears BF.
- R10: In strobed output mode, a port write clears INTR and sets BF. The falling strobe clears BF, and the rising strobe sets INTR.
- R11: Each INTE output follows its command enable bit, and INTR stays low whenever INTE is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_a | input | 1 | Port A direction, 1 = output |
| dir_b | input | 1 | Port B direction, 1 = output |
| pc_mode | input | 2 | Port C mode code |
| ie_a | input | 1 | Port A interrupt enable |
| ie_b | input | 1 | Port B interrupt enable |
| wr_a | input | 1 | Write pulse, port A |
| wr_b | input | 1 | Write pulse, port B |
| wr_c | input | 1 | Write pulse, port C |
| wr_data | input | 8 | Write data |
| rd_a | input | 1 | Read level, port A |
| rd_b | input | 1 | Read level, port B |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin output values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 6 | Port C pin inputs |
| pc_out | output | 6 | Port C pin output values |
| pc_oe | output | 6 | Port C output enables |
| a_rdata | output | 8 | Port A readback |
| b_rdata | output | 8 | Port B readback |
| c_rdata | output | 6 | Port C readback |
| a_intr | output | 1 | Port A interrupt request |
| a_bf | output | 1 | Port A buffer full |
| a_inte | output | 1 | Port A interrupt enable status |
| b_intr | output | 1 | Port B interrupt request |
| b_bf | output | 1 | Port B buffer full |
| b_inte | output | 1 | Port B interrupt enable status |

## Verification
The assertions assume that write strobes are single-cycle pulses, and that write data is valid in the cycle the pulse is high. They also assume that command bits change only between accesses, never in the same cycle as a write to the affected port. The stimulus drives every input on the falling clock edge and holds each level for several cycles before the next change. It applies random writes, direction flips and pin patterns only while port C is in mode 00, so the handshake logic stays idle. The strobe sequences are directed and keep the strobe high at rest.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PC_W = 6;

  typedef enum logic [1:0] {
    PCM_IN   = 2'b00,
    PCM_HSA  = 2'b01,
    PCM_HSAB = 2'b10,
    PCM_OUT  = 2'b11
  } pc_mode_e;

  // handshake bit positions on port C
  localparam int A_INTR_BIT = 0;
  localparam int A_BF_BIT   = 1;
  localparam int A_STB_BIT  = 2;
  localparam int B_INTR_BIT = 3;
  localparam int B_BF_BIT   = 4;
  localparam int B_STB_BIT  = 5;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pport_port.sv
module pport_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir,
  input  logic         strobed,
  input  logic         inte,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  input  logic [W-1:0] pin_s,
  input  logic         stb_s,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rdata,
  output logic         intr,
  output logic         bf
);
  logic [W-1:0] out_lat, in_lat;
  logic stb_q, rd_q, strobed_q, dir_q;
  logic stb_fall, stb_rise, rd_rise, rd_fall, enter;

  assign stb_fall = stb_q & ~stb_s;
  assign stb_rise = ~stb_q & stb_s;
  assign rd_rise  = ~rd_q & rd;
  assign rd_fall  = rd_q & ~rd;
  assign enter    = strobed & (~strobed_q | (dir != dir_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b1;
      rd_q <= 1'b0;
      strobed_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      stb_q <= stb_s;
      rd_q <= rd;
      strobed_q <= strobed;
      dir_q <= dir;
    end
  end

  // output latch: cleared and write-protected in input mode
  always_ff @(posedge clk) begin
    if (rst || !dir) out_lat <= '0;
    else if (wr) out_lat <= wdata;
  end

  // strobed input capture while the strobe is low
  always_ff @(posedge clk) begin
    if (rst) in_lat <= '0;
    else if (strobed && !dir && !stb_s) in_lat <= pin_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !strobed) begin
      bf <= 1'b0;
      intr <= 1'b0;
    end else if (enter) begin
      bf <= 1'b0;
      intr <= dir & inte;
    end else begin
      if (!dir) begin
        if (stb_fall) bf <= 1'b1;
        if (rd_fall) bf <= 1'b0;
        if (stb_rise) intr <= 1'b1;
        if (rd_rise) intr <= 1'b0;
      end else begin
        if (wr) begin
          bf <= 1'b1;
          intr <= 1'b0;
        end
        if (stb_fall) bf <= 1'b0;
        if (stb_rise) intr <= 1'b1;
      end
      if (!inte) intr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe <= '0;
      rdata <= '0;
    end else begin
      pin_oe <= {W{dir}};
      rdata <= dir ? out_lat : (strobed ? in_lat : pin_s);
    end
  end

  assign pin_out = out_lat;
endmodule

// File: rtl/pport_cmux.sv
module pport_cmux
  import pport_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode,
  input  logic            wr,
  input  logic [PC_W-1:0] wdata,
  input  logic [PC_W-1:0] pin_s,
  input  logic            a_intr,
  input  logic            a_bf,
  input  logic            b_intr,
  input  logic            b_bf,
  output logic            a_strobed,
  output logic            b_strobed,
  output logic            a_stb,
  output logic            b_stb,
  output logic [PC_W-1:0] pc_out,
  output logic [PC_W-1:0] pc_oe,
  output logic [PC_W-1:0] rdata
);
  logic [PC_W-1:0] plain_mask, hs_oe, hs_val, lat, oe_n, out_n;

  always_comb begin
    a_strobed = (mode == PCM_HSA) || (mode == PCM_HSAB);
    b_strobed = (mode == PCM_HSAB);
    a_stb = a_strobed ? pin_s[A_STB_BIT] : 1'b1;
    b_stb = b_strobed ? pin_s[B_STB_BIT] : 1'b1;
    plain_mask = '0;
    hs_oe = '0;
    hs_val = '0;
    case (pc_mode_e'(mode))
      PCM_OUT: plain_mask = '1;
      PCM_HSA: plain_mask[5:3] = 3'b111;
      default: plain_mask = '0;
    endcase
    if (a_strobed) begin
      hs_oe[A_INTR_BIT] = 1'b1;
      hs_oe[A_BF_BIT] = 1'b1;
      hs_val[A_INTR_BIT] = a_intr;
      hs_val[A_BF_BIT] = a_bf;
    end
    if (b_strobed) begin
      hs_oe[B_INTR_BIT] = 1'b1;
      hs_oe[B_BF_BIT] = 1'b1;
      hs_val[B_INTR_BIT] = b_intr;
      hs_val[B_BF_BIT] = b_bf;
    end
    oe_n = plain_mask | hs_oe;
    out_n = (lat & plain_mask) | hs_val;
  end

  always_ff @(posedge clk) begin
    if (rst) lat <= '0;
    else begin
      for (int i = 0; i < PC_W; i++) begin
        if (!plain_mask[i]) lat[i] <= 1'b0;
        else if (wr) lat[i] <= wdata[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out <= '0;
      pc_oe <= '0;
      rdata <= '0;
    end else begin
      pc_out <= out_n;
      pc_oe <= oe_n;
      rdata <= (oe_n & out_n) | (~oe_n & pin_s);
    end
  end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int PW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dir_a,
  input  logic            dir_b,
  input  logic [1:0]      pc_mode,
  input  logic            ie_a,
  input  logic            ie_b,
  input  logic            wr_a,
  input  logic            wr_b,
  input  logic            wr_c,
  input  logic [PW-1:0]   wr_data,
  input  logic            rd_a,
  input  logic            rd_b,
  input  logic [PW-1:0]   pa_in,
  output logic [PW-1:0]   pa_out,
  output logic [PW-1:0]   pa_oe,
  input  logic [PW-1:0]   pb_in,
  output logic [PW-1:0]   pb_out,
  output logic [PW-1:0]   pb_oe,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] pc_out,
  output logic [PC_W-1:0] pc_oe,
  output logic [PW-1:0]   a_rdata,
  output logic [PW-1:0]   b_rdata,
  output logic [PC_W-1:0] c_rdata,
  output logic            a_intr,
  output logic            a_bf,
  output logic            a_inte,
  output logic            b_intr,
  output logic            b_bf,
  output logic            b_inte
);
  localparam int NP = 2;

  logic [PC_W-1:0] pc_s;
  logic [NP-1:0][PW-1:0] pin_s, p_in, p_out, p_oe, p_rd;
  logic [NP-1:0] p_dir, p_strb, p_ie, p_wr, p_rdl, p_stb, p_intr, p_bf;
  logic [NP-1:0] inte_q;

  assign p_in  = {pb_in, pa_in};
  assign p_dir = {dir_b, dir_a};
  assign p_ie  = {ie_b, ie_a};
  assign p_wr  = {wr_b, wr_a};
  assign p_rdl = {rd_b, rd_a};

  pport_sync #(.W(PC_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_c (
    .clk(clk), .rst(rst), .d(pc_in), .q(pc_s)
  );

  for (genvar g = 0; g < NP; g++) begin : g_port
    pport_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
      .clk(clk), .rst(rst), .d(p_in[g]), .q(pin_s[g])
    );
    pport_port #(.W(PW)) u_port (
      .clk(clk), .rst(rst), .dir(p_dir[g]), .strobed(p_strb[g]),
      .inte(p_ie[g]), .wr(p_wr[g]), .wdata(wr_data), .rd(p_rdl[g]),
      .pin_s(pin_s[g]), .stb_s(p_stb[g]), .pin_out(p_out[g]),
      .pin_oe(p_oe[g]), .rdata(p_rd[g]), .intr(p_intr[g]), .bf(p_bf[g])
    );
  end

  pport_cmux u_cmux (
    .clk(clk), .rst(rst), .mode(pc_mode), .wr(wr_c), .wdata(wr_data[PC_W-1:0]),
    .pin_s(pc_s), .a_intr(p_intr[0]), .a_bf(p_bf[0]), .b_intr(p_intr[1]),
    .b_bf(p_bf[1]), .a_strobed(p_strb[0]), .b_strobed(p_strb[1]),
    .a_stb(p_stb[0]), .b_stb(p_stb[1]), .pc_out(pc_out), .pc_oe(pc_oe),
    .rdata(c_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) inte_q <= '0;
    else inte_q <= p_ie;
  end

  assign pa_out = p_out[0];
  assign pb_out = p_out[1];
  assign pa_oe = p_oe[0];
  assign pb_oe = p_oe[1];
  assign a_rdata = p_rd[0];
  assign b_rdata = p_rd[1];
  assign a_intr = p_intr[0];
  assign b_intr = p_intr[1];
  assign a_bf = p_bf[0];
  assign b_bf = p_bf[1];
  assign a_inte = inte_q[0];
  assign b_inte = inte_q[1];
endmodule

// File: rtl/pport_ctrl_chk.sv
module pport_ctrl_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          dir_a,
  input logic          wr_a,
  input logic [PW-1:0] wr_data,
  input logic [1:0]    pc_mode,
  input logic [PW-1:0] pa_out,
  input logic [PW-1:0] pa_oe,
  input logic [PW-1:0] pb_out,
  input logic [PW-1:0] pb_oe,
  input logic [5:0]    pc_oe,
  input logic          a_intr,
  input logic          a_bf,
  input logic          a_inte,
  input logic          b_intr,
  input logic          b_inte
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && pa_out == '0 && !a_intr && !a_bf));
  // R2
  oe_all_or_none_chk: assert property (@(posedge clk) disable iff (rst)
    (pa_oe == '0) || (pa_oe == '1));
  // R3
  input_latch_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pb_oe == '0) |-> (pb_out == '0));
  // R3
  wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir_a && wr_a) |=> (pa_out == '0));
  // R2
  wr_drives_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_a && wr_a) |=> (pa_out == $past(wr_data)));
  // R7
  plain_mode_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_mode == 2'b00) |=> (!a_intr && !a_bf));
  // R11
  intr_gated_a_chk: assert property (@(posedge clk) disable iff (rst)
    !a_inte |-> !a_intr);
  // R11
  intr_gated_b_chk: assert property (@(posedge clk) disable iff (rst)
    !b_inte |-> !b_intr);
endmodule

bind pport_ctrl pport_ctrl_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .dir_a(dir_a), .wr_a(wr_a), .wr_data(wr_data),
  .pc_mode(pc_mode), .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out),
  .pb_oe(pb_oe), .pc_oe(pc_oe), .a_intr(a_intr), .a_bf(a_bf), .a_inte(a_inte),
  .b_intr(b_intr), .b_inte(b_inte)
);

// File: tb/pport_ctrl_bench.sv
module pport_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_a = 0, dir_b = 0, ie_a = 0, ie_b = 0;
  logic [1:0] pc_mode = 2'b00;
  logic wr_a = 0, wr_b = 0, wr_c = 0, rd_a = 0, rd_b = 0;
  logic [7:0] wr_data = 0, pa_in = 0, pb_in = 0;
  logic [5:0] pc_in = 6'b100100;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, a_rdata, b_rdata;
  logic [5:0] pc_out, pc_oe, c_rdata;
  logic a_intr, a_bf, a_inte, b_intr, b_bf, b_inte;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pport_ctrl u_pport_ctrl (
    .clk(clk), .rst(rst), .dir_a(dir_a), .dir_b(dir_b), .pc_mode(pc_mode),
    .ie_a(ie_a), .ie_b(ie_b), .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c),
    .wr_data(wr_data), .rd_a(rd_a), .rd_b(rd_b), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe), .a_rdata(a_rdata), .b_rdata(b_rdata),
    .c_rdata(c_rdata), .a_intr(a_intr), .a_bf(a_bf), .a_inte(a_inte),
    .b_intr(b_intr), .b_bf(b_bf), .b_inte(b_inte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr_port(input int p, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    if (p == 0) wr_a = 1; else if (p == 1) wr_b = 1; else wr_c = 1;
    @(negedge clk);
    wr_a = 0; wr_b = 0; wr_c = 0;
    settle();
  endtask

  function automatic logic [7:0] exp_rd(input logic dir, input logic [7:0] lat, input logic [7:0] pin);
    return dir ? lat : pin;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ma, mb;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 0;
    settle();
    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 6'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 flags", {a_intr, a_bf, b_intr, b_bf}, 4'h0);

    // R2 R3 R4 random basic-mode traffic
    ma = 0; mb = 0;
    for (int it = 0; it < 40; it++) begin
      int op;
      logic [7:0] d;
      op = $urandom % 3;
      d = 8'($urandom);
      case (op)
        0: begin @(negedge clk); dir_a = ~dir_a; ma = 0; end
        1: begin if (dir_a) ma = d; wr_port(0, d); end
        default: begin @(negedge clk); pa_in = d; end
      endcase
      op = $urandom % 3;
      d = 8'($urandom);
      case (op)
        0: begin @(negedge clk); dir_b = ~dir_b; mb = 0; end
        1: begin if (dir_b) mb = d; wr_port(1, d); end
        default: begin @(negedge clk); pb_in = d; end
      endcase
      settle();
      chk("R3 pa_out", pa_out, ma);
      chk("R2 pa_oe", pa_oe, {8{dir_a}});
      chk("R4 a_rdata", a_rdata, exp_rd(dir_a, ma, pa_in));
      chk("R3 pb_out", pb_out, mb);
      chk("R2 pb_oe", pb_oe, {8{dir_b}});
      chk("R4 b_rdata", b_rdata, exp_rd(dir_b, mb, pb_in));
    end

    // R3 directed: write ignored in input, zero on switch
    @(negedge clk); dir_a = 0; settle();
    wr_port(0, 8'h5A);
    chk("R3 ignored write", pa_out, 8'h00);
    @(negedge clk); dir_a = 1; settle();
    chk("R3 switch low", pa_out, 8'h00);
    wr_port(0, 8'hC3);
    wr_port(0, 8'hC3);
    chk("R4 out readback", a_rdata, 8'hC3);
    chk("R2 pins", pa_out, 8'hC3);

    // R5 port C plain modes
    @(negedge clk); pc_mode = 2'b11; settle();
    wr_port(2, 8'h2A);
    chk("R5 pc_out", pc_out, 6'h2A);
    chk("R5 pc_oe", pc_oe, 6'h3F);
    chk("R5 c_rdata out", c_rdata, 6'h2A);
    @(negedge clk); pc_mode = 2'b00; pc_in = 6'b110101; settle();
    chk("R5 pc_oe in", pc_oe, 6'h00);
    chk("R5 c_rdata in", c_rdata, 6'b110101);
    @(negedge clk); pc_in = 6'b100100; settle();

    // R6 R7 mode 01, A strobed input
    @(negedge clk); dir_a = 0; ie_a = 1; pc_mode = 2'b01; settle();
    chk("R6 oe mode01", pc_oe, 6'b111011);
    chk("R7 entry in", {a_intr, a_bf}, 2'b00);
    chk("R11 inte", a_inte, 1'b1);
    wr_port(2, 8'h38);
    chk("R6 plain out bits", pc_out[5:3], 3'b111);
    // R8 strobed input
    @(negedge clk); pa_in = 8'h77; settle();
    @(negedge clk); pc_in[2] = 0; settle();
    chk("R8 bf set", a_bf, 1'b1);
    chk("R8 intr not yet", a_intr, 1'b0);
    @(negedge clk); pc_in[2] = 1; settle();
    @(negedge clk); pa_in = 8'h11; settle();
    chk("R8 intr set", a_intr, 1'b1);
    chk("R8 latched data", a_rdata, 8'h77);
    chk("R6 pc0 pc1", pc_out[1:0], 2'b11);
    // R9 read clears
    @(negedge clk); rd_a = 1; settle();
    chk("R9 intr cleared", a_intr, 1'b0);
    chk("R9 bf held", a_bf, 1'b1);
    @(negedge clk); rd_a = 0; settle();
    chk("R9 bf cleared", a_bf, 1'b0);
    // R11 disabled interrupt
    @(negedge clk); ie_a = 0; settle();
    @(negedge clk); pc_in[2] = 0; settle();
    @(negedge clk); pc_in[2] = 1; settle();
    chk("R11 intr gated", a_intr, 1'b0);
    chk("R11 inte low", a_inte, 1'b0);
    // R7 R10 strobed output
    @(negedge clk); ie_a = 1; dir_a = 1; settle();
    chk("R7 entry out", {a_intr, a_bf}, 2'b10);
    wr_port(0, 8'h3C);
    chk("R10 write flags", {a_intr, a_bf}, 2'b01);
    chk("R10 data", pa_out, 8'h3C);
    @(negedge clk); pc_in[2] = 0; settle();
    chk("R10 ack clears bf", a_bf, 1'b0);
    @(negedge clk); pc_in[2] = 1; settle();
    chk("R10 intr set", a_intr, 1'b1);

    // R6 R8 mode 10, B strobed input
    @(negedge clk); dir_b = 0; ie_b = 1; pc_mode = 2'b10; settle();
    chk("R6 oe mode10", pc_oe, 6'b011011);
    @(negedge clk); pb_in = 8'hE1; pc_in[5] = 0; settle();
    @(negedge clk); pc_in[5] = 1; settle();
    chk("R8 b flags", {b_intr, b_bf}, 2'b11);
    chk("R6 pc3 pc4", pc_out[4:3], 2'b11);
    chk("R8 b data", b_rdata, 8'hE1);

    // R7 leaving handshake mode
    @(negedge clk); pc_mode = 2'b00; settle();
    chk("R7 idle flags", {a_intr, a_bf, b_intr, b_bf}, 4'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule